// File: doc/BRIEF.md
# Task-Driven Random Byte Generator

This block makes 8-bit pseudo-random values on demand and is controlled by tasks and events. Software, or a hardware trigger line, issues a start task to begin continuous generation and a stop task to end it. While the block runs, a down-counter measures out a fixed generation interval. When the interval expires, a new byte lands in the value register, a value-ready event flag is set, a one-cycle event pulse goes out, and an interrupt can be raised.

The generation interval depends on a bias-filter enable. With the filter on, each byte takes a longer interval; with it off, a shorter one. Both intervals are given in microseconds and are turned into clock cycles with a clock-frequency parameter. A shortcut bit can make the block stop by itself after the next value-ready event, so one start gives exactly one byte. The entropy source is a deterministic Galois LFSR stand-in.

The register bus is a simple single-cycle write strobe with a combinational read. All registers take 32-bit data, and only bit 0 (or bits 7:0 of the value) is significant.

Top module: `rng_evt_periph`

## Requirements
- R1: After reset every register reads 0, the value register reads 0, and both `evt_ready` and `irq` are low.
- R2: Each new value equals the LFSR state after eight right-shift Galois steps. In each step, if the low bit is 1 the shifted state is XORed with 0xB8. The LFSR starts from 0x5A and carries on across values. The value register (offset 0x508, bits 7:0) changes only when a new value is produced.
- R3: When a value is produced, the event register (offset 0x100, bit 0) reads 1 and `evt_ready` is high for exactly one cycle. The event register and `evt_ready` go high in the same cycle that the value updates.
- R4: With config bit 0 (offset 0x504) clear, the first value appears UNFILT_US*CLK_MHZ cycles after the clock edge that takes the start task. Each later value follows the one before by the same number of cycles. An idle block produces nothing.
- R5: With config bit 0 set, the interval is FILT_US*CLK_MHZ cycles. The config value in effect when the counter reloads picks the interval.
- R6: When shortcut bit 0 (offset 0x200) is set at the moment a value is produced, generation stops, so only one value comes out until the next start task.
- R7: The interrupt enable (offset 0x300, bit 0) is loaded by a write there. A write with bit 0 = 1 to offset 0x304 sets it, and a write with bit 0 = 1 to offset 0x308 clears it. All three offsets read back the enable.
- R8: `irq` is high exactly while the event register and the interrupt enable are both 1.
- R9: A write to offset 0x100 loads bit 0 into the event register, so writing 0 clears it. If a value is produced in the same cycle, the event register ends up set.
- R10: A one-cycle high on `trig_start` or `trig_stop` has the same effect as a bus write with bit 0 = 1 to offset 0x000 (start) or 0x004 (stop).
- R11: A stop task wins over a start task in the same cycle. Any task in a cycle stops a value from being produced in that cycle. A start task while the block is running restarts the interval.
- R12: Writes to the value register have no effect. Task offsets and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset inside the 4 KiB register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| trig_start | input | 1 | Hardware start task pulse |
| trig_stop | input | 1 | Hardware stop task pulse |
| evt_ready | output | 1 | One-cycle pulse when a new value is stored |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions take it for granted that both configured intervals are at least one cycle long. They also assume that `bus_addr`, `bus_wr` and the trigger lines are known values at every clock edge after reset, because a task decoded from an unknown strobe would make the production cycle ambiguous. The stimulus drives every input on the falling edge, keeps addresses inside the defined map except for one deliberate unmapped read, and holds writes and triggers to single-cycle strobes. Collisions between tasks, and between an event clear and a production, are created on purpose in known cycles, so the priority rules are exercised rather than left to chance.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int VAL_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_GO      = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_HALT    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EVENT   = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_SHORT   = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_IEN_SET = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_IEN_CLR = 12'h308;
    localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h504;
    localparam logic [ADDR_W-1:0] OFS_VALUE   = 12'h508;

    localparam logic [VAL_W-1:0] LFSR_SEED = 8'h5A;
    localparam logic [VAL_W-1:0] LFSR_TAPS = 8'hB8;
    localparam int               LFSR_STEPS = 8;

    typedef struct packed {
        logic             active;
        logic             evt;
        logic             pulse;
        logic             short_en;
        logic             int_en;
        logic             filt_en;
        logic [VAL_W-1:0] value;
        logic [VAL_W-1:0] lfsr;
    } core_state_t;

endpackage

// File: rtl/rng_lfsr_adv.sv
module rng_lfsr_adv #(
    parameter int           W     = 8,
    parameter int           STEPS = 8,
    parameter logic [W-1:0] TAPS  = 8'hB8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic [W-1:0] chain [0:STEPS];

    assign chain[0] = cur;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign chain[i+1] = chain[i][0] ? ((chain[i] >> 1) ^ TAPS) : (chain[i] >> 1);
    end

    assign nxt = chain[STEPS];

endmodule

// File: rtl/rng_interval_timer.sv
module rng_interval_timer #(
    parameter int               CNT_W        = 8,
    parameter logic [CNT_W-1:0] RELOAD_SHORT = '0,
    parameter logic [CNT_W-1:0] RELOAD_LONG  = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic long_sel,
    output logic expire
);

    localparam logic [CNT_W-1:0] RELOAD_MAX =
        (RELOAD_LONG > RELOAD_SHORT) ? RELOAD_LONG : RELOAD_SHORT;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = long_sel ? RELOAD_LONG : RELOAD_SHORT;
    assign expire     = run && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = reload_val;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_d = reload_val;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the counter never holds more than the longest reload
    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD_MAX);

endmodule

// File: rtl/rng_evt_periph.sv
module rng_evt_periph
    import rng_pkg::*;
#(
    parameter int CLK_MHZ   = 16,
    parameter int UNFILT_US = 30,
    parameter int FILT_US   = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_start,
    input  logic              trig_stop,
    output logic              evt_ready,
    output logic              irq
);

    localparam int UNF_CYC = UNFILT_US * CLK_MHZ;
    localparam int FLT_CYC = FILT_US * CLK_MHZ;
    localparam int MAX_CYC = (FLT_CYC > UNF_CYC) ? FLT_CYC : UNF_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RLD_UNF = CNT_W'(UNF_CYC - 1);
    localparam logic [CNT_W-1:0] RLD_FLT = CNT_W'(FLT_CYC - 1);

    core_state_t st_d, st_q;

    logic             start_tsk, stop_tsk, produce, tmr_expire;
    logic [VAL_W-1:0] lfsr_nxt;
    logic             wbit;
    logic             unused_wdata;

    assign wbit         = bus_wdata[0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:1];

    assign start_tsk = trig_start || (bus_wr && (bus_addr == OFS_GO)   && wbit);
    assign stop_tsk  = trig_stop  || (bus_wr && (bus_addr == OFS_HALT) && wbit);
    assign produce   = st_q.active && tmr_expire && !start_tsk && !stop_tsk;

    rng_lfsr_adv #(
        .W    (VAL_W),
        .STEPS(LFSR_STEPS),
        .TAPS (LFSR_TAPS)
    ) lfsr_i (
        .cur(st_q.lfsr),
        .nxt(lfsr_nxt)
    );

    rng_interval_timer #(
        .CNT_W       (CNT_W),
        .RELOAD_SHORT(RLD_UNF),
        .RELOAD_LONG (RLD_FLT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_tsk),
        .run     (st_q.active),
        .long_sel(st_q.filt_en),
        .expire  (tmr_expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (stop_tsk) begin
            st_d.active = 1'b0;
        end else if (start_tsk) begin
            st_d.active = 1'b1;
        end else if (produce) begin
            st_d.pulse = 1'b1;
            st_d.value = lfsr_nxt;
            st_d.lfsr  = lfsr_nxt;
            if (st_q.short_en) begin
                st_d.active = 1'b0;
            end
        end

        if (bus_wr) begin
            case (bus_addr)
                OFS_EVENT:   st_d.evt      = wbit;
                OFS_SHORT:   st_d.short_en = wbit;
                OFS_IEN:     st_d.int_en   = wbit;
                OFS_IEN_SET: if (wbit) st_d.int_en = 1'b1;
                OFS_IEN_CLR: if (wbit) st_d.int_en = 1'b0;
                OFS_CFG:     st_d.filt_en  = wbit;
                default:     ;
            endcase
        end

        if (produce) begin
            st_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_EVENT:   bus_rdata[0] = st_q.evt;
            OFS_SHORT:   bus_rdata[0] = st_q.short_en;
            OFS_IEN,
            OFS_IEN_SET,
            OFS_IEN_CLR: bus_rdata[0] = st_q.int_en;
            OFS_CFG:     bus_rdata[0] = st_q.filt_en;
            OFS_VALUE:   bus_rdata[VAL_W-1:0] = st_q.value;
            default:     bus_rdata = '0;
        endcase
    end

    assign evt_ready = st_q.pulse;
    assign irq       = st_q.evt && st_q.int_en;

    // R2: a fresh value always differs from the one before it
    p_value_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ready |-> (st_q.value != $past(st_q.value)));

    // R2: the value holds between productions
    p_value_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_ready |-> $stable(st_q.value));

    // R3: the pulse comes with the event flag set
    p_pulse_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ready |-> st_q.evt);

    // R4: an idle block emits no event on the next cycle
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |=> !evt_ready);

    // R6: with the shortcut on, a production leaves the block stopped
    p_short_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ready && $past(st_q.short_en)) |-> !st_q.active);

endmodule

// File: tb/rng_evt_periph_tb_top.sv
module rng_evt_periph_tb_top;

    localparam int CLK_MHZ   = 2;
    localparam int UNFILT_US = 3;
    localparam int FILT_US   = 8;
    localparam int P_UNF     = CLK_MHZ * UNFILT_US;
    localparam int P_FLT     = CLK_MHZ * FILT_US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_start = 1'b0;
    logic        trig_stop = 1'b0;
    logic        evt_ready;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rng_evt_periph #(
        .CLK_MHZ  (CLK_MHZ),
        .UNFILT_US(UNFILT_US),
        .FILT_US  (FILT_US)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trig_start(trig_start),
        .trig_stop (trig_stop),
        .evt_ready (evt_ready),
        .irq       (irq)
    );

    // behavioural reference model
    int m_active = 0, m_cnt = 0, m_evt = 0, m_short = 0, m_ien = 0;
    int m_filt = 0, m_val = 0, m_lfsr = 'h5A, m_pulse = 0;

    function automatic int lfsr8(input int s);
        int x = s;
        for (int k = 0; k < 8; k++) begin
            if (x % 2 == 1) x = (x / 2) ^ 'hB8;
            else            x = x / 2;
        end
        return x;
    endfunction

    function automatic int m_read(input int a);
        case (a)
            'h100: return m_evt;
            'h200: return m_short;
            'h300, 'h304, 'h308: return m_ien;
            'h504: return m_filt;
            'h508: return m_val;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_cnt = 0; m_evt = 0; m_short = 0; m_ien = 0;
            m_filt = 0; m_val = 0; m_lfsr = 'h5A; m_pulse = 0;
        end else begin
            bit go, halt, prod, w;
            int a, per, n_evt, n_ien;
            w    = bus_wr;
            a    = int'(bus_addr);
            go   = trig_start || (w && a == 0 && bus_wdata[0]);
            halt = trig_stop  || (w && a == 4 && bus_wdata[0]);
            per  = (m_filt != 0) ? P_FLT : P_UNF;
            prod = (m_active != 0) && m_cnt == 0 && !go && !halt;
            m_pulse = prod;
            n_evt = m_evt;
            n_ien = m_ien;
            if (w && a == 'h100) n_evt = bus_wdata[0];
            if (w && a == 'h300) n_ien = bus_wdata[0];
            if (w && a == 'h304 && bus_wdata[0]) n_ien = 1;
            if (w && a == 'h308 && bus_wdata[0]) n_ien = 0;
            if (prod) n_evt = 1;
            if (halt) begin
                m_active = 0;
            end else if (go) begin
                m_active = 1;
                m_cnt = per - 1;
            end else if (m_active != 0) begin
                if (m_cnt == 0) begin
                    m_lfsr = lfsr8(m_lfsr);
                    m_val  = m_lfsr;
                    m_cnt  = per - 1;
                    if (m_short != 0) m_active = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            m_evt = n_evt;
            m_ien = n_ien;
            if (w && a == 'h200) m_short = bus_wdata[0];
            if (w && a == 'h504) m_filt  = bus_wdata[0];
        end
    end

    // R3 / R8: outputs compared with the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (evt_ready !== m_pulse[0]) begin
                fails++;
                $display("FAIL R3 evt_ready actual=%0b expected=%0d", evt_ready, m_pulse);
            end
            tests++;
            if (irq !== (m_evt != 0 && m_ien != 0)) begin
                fails++;
                $display("FAIL R8 irq actual=%0b expected=%0d", irq, (m_evt != 0 && m_ien != 0));
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input string req, input int a);
        @(negedge clk);
        bus_addr = 12'(a);
        #1;
        check(req, int'(bus_rdata), m_read(a));
    endtask

    task automatic measure(input string req, input int exp);
        int j = 0;
        while (!evt_ready && j < 100) begin
            @(negedge clk);
            j++;
        end
        check(req, j, exp);
    endtask

    task automatic count_pulses(input string req, input int cyc, input int exp);
        int n = 0;
        repeat (cyc) begin
            @(negedge clk);
            if (evt_ready) n++;
        end
        check(req, n, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 evt_ready", evt_ready, 0);
        check("R1 irq", irq, 0);
        check("R1 value", m_read('h508), 0);
        rd("R1 value read", 'h508);
        rd("R1 enable read", 'h300);
        rd("R1 config read", 'h504);

        // R7 interrupt enable aliases
        wr('h304, 1);
        rd("R7 set via alias", 'h300);
        check("R7 enable set", int'(bus_rdata), 1);
        wr('h308, 1);
        rd("R7 clear via alias", 'h304);
        check("R7 enable clear", int'(bus_rdata), 0);
        wr('h308, 0);
        wr('h300, 1);
        rd("R7 direct write", 'h308);

        // R4 unfiltered interval, R2 value, R3 event
        wr('h000, 1);
        measure("R4 first interval", P_UNF);
        check("R2 first value", m_val, lfsr8('h5A));
        @(negedge clk);
        measure("R4 next interval", P_UNF - 1);
        check("R2 second value", m_val, lfsr8(lfsr8('h5A)));
        rd("R2 value read", 'h508);
        rd("R3 event read", 'h100);
        check("R8 irq high", irq, 1);
        wr('h004, 1);
        count_pulses("R4 stopped quiet", 2 * P_UNF, 0);

        // R9 clear event, R8 enable gating
        wr('h100, 0);
        rd("R9 event cleared", 'h100);
        check("R9 irq low", irq, 0);
        wr('h100, 1);
        wr('h308, 1);
        check("R8 masked irq", irq, 0);
        wr('h100, 0);
        wr('h304, 1);

        // R5 filtered interval
        wr('h504, 1);
        wr('h000, 1);
        measure("R5 filtered interval", P_FLT);
        // R9 clear write colliding with a production: set wins
        repeat (P_FLT - 2) @(negedge clk);
        wr('h100, 0);
        rd("R9 collision keeps event", 'h100);
        check("R9 collision event", int'(bus_rdata), 1);
        wr('h004, 1);

        // R6 shortcut
        wr('h504, 0);
        wr('h200, 1);
        wr('h000, 1);
        count_pulses("R6 single value", 4 * P_UNF, 1);
        wr('h200, 0);

        // R10 hardware triggers
        @(negedge clk); trig_start = 1'b1;
        @(negedge clk); trig_start = 1'b0;
        measure("R10 hw start interval", P_UNF);
        @(negedge clk); trig_stop = 1'b1;
        @(negedge clk); trig_stop = 1'b0;
        count_pulses("R10 hw stop quiet", 3 * P_UNF, 0);

        // R11 stop beats start; restart on start while running
        @(negedge clk); trig_start = 1'b1; trig_stop = 1'b1;
        @(negedge clk); trig_start = 1'b0; trig_stop = 1'b0;
        count_pulses("R11 stop wins", 3 * P_UNF, 0);
        wr('h000, 1);
        repeat (P_UNF - 2) @(negedge clk);
        wr('h000, 1);
        measure("R11 restart interval", P_UNF);
        wr('h004, 1);

        // R12 read-only and unmapped offsets
        wr('h508, 'hFF);
        rd("R12 value unchanged", 'h508);
        check("R12 value kept", int'(bus_rdata), m_val);
        rd("R12 task reads zero", 'h000);
        rd("R12 unmapped zero", 'h7FC);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule